// File: doc/BRIEF.md
# Priority Interrupt Source Selector

This block steers event sources onto a small set of CPU interrupt lines. There are 128 event levels at its input and twelve interrupt outputs. The outputs are bound in order to CPU priority levels 4 through 15. Each output owns an 8-bit source-select field. The field names the event whose level the output carries. Software writes these fields through a small register port and can read them back.

The selector fields are packed four to a 32-bit word. Output k sits in bank word 1 + k/4, at bits (k%4)*8 to (k%4)*8+7. Bank word 0 is reserved. Event numbers 0 to 3 are the four group-combined events, and they can be selected like any other event. A field value of 128 or more leaves its output unmapped and held low. Each output is registered, so it follows its selected event one clock later.

Top module: `irq_src_sel`

## Requirements
- R1: After a synchronous reset every selector field holds 0xFF. Bank words 1 to 3 therefore read 0xFFFFFFFF, and all twelve interrupt outputs are low.
- R2: Output k takes its select field from bank word 1 + k/4, at bits (k%4)*8+7 down to (k%4)*8.
- R3: Bank word 0 always reads 0. A write to it changes no field and no output.
- R4: A write to bank word 1, 2 or 3 replaces all four fields of that word in the same clock edge. A read of that word returns the stored value.
- R5: When an output's field is below 128, the output equals the level of the selected event as sampled at the previous rising clock edge.
- R6: When an output's field is 128 or more, the output is low whatever the event inputs are.
- R7: The boundary event numbers 0 (a group-combined event) and 127 can both be selected.
- R8: Several outputs may select the same event at once, and each of them follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 128 | Event levels; bit n is event n |
| reg_we_i | input | 1 | Write strobe for the selector bank |
| reg_addr_i | input | 2 | Bank word index (0 is reserved) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 12 | Interrupt lines; bit k serves priority 4+k |

## Verification
The bench builds the block with its default parameters: 128 events, twelve outputs and 8-bit fields. With 8-bit fields the out-of-range codes 128 to 255 can be written, so the unmapped case is reachable. With twelve outputs, all three selector words are full, so every field position of the packing is exercised. The 128-event width also puts the extreme sources 0 and 127 within reach for the boundary checks.

// File: rtl/irq_src_sel_pkg.sv
package irq_src_sel_pkg;
    localparam int SEL_W = 8;
    typedef logic [SEL_W-1:0] sel_t;
    localparam sel_t SEL_UNMAPPED = '1;
endpackage

// File: rtl/irq_sel_bank.sv
module irq_sel_bank
    import irq_src_sel_pkg::*;
#(
    parameter int NUM_OUTS = 12,
    parameter int DATA_W   = 32,
    localparam int FPW       = DATA_W / SEL_W,
    localparam int NUM_WORDS = (NUM_OUTS + FPW - 1) / FPW,
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output sel_t              sel_o [NUM_OUTS]
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  addr_ok;
    int    widx;

    // word 0 is reserved; selector words start at index 1
    always_comb begin
        addr_ok = (addr_i != '0) && (int'(addr_i) <= NUM_WORDS);
        widx    = int'(addr_i) - 1;
        bank_d  = bank_q;
        rdata_o = '0;
        if (addr_ok) begin
            rdata_o = bank_q.words[widx];
            if (we_i) begin
                bank_d.words[widx] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bank_q <= '{words: {NUM_WORDS{{FPW{SEL_UNMAPPED}}}}};
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_field
        assign sel_o[k] = bank_q.words[k / FPW][(k % FPW) * SEL_W +: SEL_W];
    end

    AST_RSV_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == '0) |-> (rdata_o == '0)); // R3
    AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_ok) |=> (($past(addr_i) != addr_i) || (rdata_o == $past(wdata_i)))); // R4
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(we_i && addr_ok) |=> $stable(bank_q)); // R3
endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
    import irq_src_sel_pkg::*;
#(
    parameter int NUM_EVENTS = 128,
    parameter int NUM_OUTS   = 12,
    localparam int IDX_W     = $clog2(NUM_EVENTS)
) (
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  sel_t                  sel_i [NUM_OUTS],
    output logic [NUM_OUTS-1:0]   hit_o
);
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
        logic in_range;
        always_comb begin
            in_range = int'(sel_i[k]) < NUM_EVENTS;
            hit_o[k] = in_range && evt_i[sel_i[k][IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/irq_src_sel.sv
module irq_src_sel
    import irq_src_sel_pkg::*;
#(
    parameter int NUM_EVENTS = 128,
    parameter int NUM_OUTS   = 12,
    parameter int DATA_W     = 32,
    localparam int FPW       = DATA_W / SEL_W,
    localparam int NUM_WORDS = (NUM_OUTS + FPW - 1) / FPW,
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1),
    localparam int IDX_W     = $clog2(NUM_EVENTS)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic [NUM_OUTS-1:0]   irq_o
);
    typedef struct packed {
        logic [NUM_OUTS-1:0] irq;
    } out_t;

    sel_t                sel [NUM_OUTS];
    logic [NUM_OUTS-1:0] hit;
    out_t                out_d, out_q;

    irq_sel_bank #(
        .NUM_OUTS (NUM_OUTS),
        .DATA_W   (DATA_W)
    ) bank_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .sel_o   (sel)
    );

    irq_src_mux #(
        .NUM_EVENTS (NUM_EVENTS),
        .NUM_OUTS   (NUM_OUTS)
    ) mux_i (
        .evt_i (evt_i),
        .sel_i (sel),
        .hit_o (hit)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = hit;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o = out_q.irq;

    AST_LOW_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (irq_o == '0)); // R1

    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_chk
        AST_UNMAPPED_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
            (int'(sel[k]) >= NUM_EVENTS) |=> !irq_o[k]); // R6
        AST_FOLLOWS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
            (int'(sel[k]) < NUM_EVENTS) |=> (irq_o[k] == $past(evt_i[sel[k][IDX_W-1:0]]))); // R5
    end
endmodule

// File: tb/irq_src_sel_tb.sv
module irq_src_sel_tb_top;
    localparam int NE = 128;
    localparam int NO = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] evt = '0;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NO-1:0] irq;

    int errors = 0;
    int checks = 0;
    int msel [NO];

    always #5 clk = ~clk;

    irq_src_sel dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .evt_i       (evt),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] model_irq();
        logic [NO-1:0] r = '0;
        for (int k = 0; k < NO; k++) begin
            if (msel[k] < NE) r[k] = evt[msel[k]];
        end
        return r;
    endfunction

    // drive at negedge, write happens at next posedge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (a != 2'd0) begin
            for (int j = 0; j < 4; j++) msel[(int'(a) - 1) * 4 + j] = int'(d[j*8 +: 8]);
        end
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // change events at negedge, result visible after one edge
    task automatic set_evt_check(string req, logic [NE-1:0] v);
        @(negedge clk);
        evt = v;
        #1;
        @(negedge clk);
        check(req, 32'(irq), 32'(model_irq()));
    endtask

    task automatic t_reset();
        check("R1 irq after reset", 32'(irq), 32'h0);
        rd_check("R1 word1", 2'd1, 32'hFFFF_FFFF);
        rd_check("R1 word2", 2'd2, 32'hFFFF_FFFF);
        rd_check("R1 word3", 2'd3, 32'hFFFF_FFFF);
        set_evt_check("R1 unmapped after reset", '1);
        check("R1 all low", 32'(irq), 32'h0);
        evt = '0;
    endtask

    task automatic t_reserved();
        wr(2'd0, 32'h1234_5678);
        rd_check("R3 reserved read", 2'd0, 32'h0);
        rd_check("R3 word1 untouched", 2'd1, 32'hFFFF_FFFF);
        set_evt_check("R3 no output change", '1);
        check("R3 outputs low", 32'(irq), 32'h0);
        evt = '0;
    endtask

    task automatic t_map();
        logic [NE-1:0] v;
        wr(2'd1, {8'd7, 8'd6, 8'd5, 8'd4});
        rd_check("R4 word1 readback", 2'd1, {8'd7, 8'd6, 8'd5, 8'd4});
        v = '0; v[5] = 1'b1;
        set_evt_check("R2 R5 event5 to out1", v);
        check("R2 out1 only", 32'(irq), 32'h002);
        // latency: change before edge must not show yet
        @(negedge clk);
        evt = '0; v = '0; v[7] = 1'b1; evt = v;
        #1;
        check("R5 no change before edge", 32'(irq), 32'h002);
        @(negedge clk);
        check("R5 one clock later", 32'(irq), 32'h008);
        wr(2'd3, {8'd127, 8'd0, 8'd3, 8'd64});
        rd_check("R4 word3 readback", 2'd3, {8'd127, 8'd0, 8'd3, 8'd64});
        v = '0; v[0] = 1'b1; v[127] = 1'b1;
        set_evt_check("R7 sources 0 and 127", v);
        check("R7 bits 10 and 11", 32'(irq), 32'hC00);
        v = '0; v[3] = 1'b1; v[64] = 1'b1;
        set_evt_check("R2 word3 low fields", v);
    endtask

    task automatic t_unmapped();
        wr(2'd2, {8'd255, 8'd200, 8'd128, 8'd9});
        rd_check("R4 word2 readback", 2'd2, {8'd255, 8'd200, 8'd128, 8'd9});
        set_evt_check("R6 all events high", '1);
        check("R6 fields 128+ low", 32'(irq), 32'hF1F);
    endtask

    task automatic t_shared();
        logic [NE-1:0] v;
        wr(2'd1, {4{8'd50}});
        v = '0; v[50] = 1'b1;
        set_evt_check("R8 shared source", v);
        check("R8 four outputs", 32'(irq), 32'h00F);
        set_evt_check("R8 shared release", '0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NO; k++) msel[k] = 255;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_map();
        t_unmapped();
        t_shared();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule